// File: doc/BRIEF.md
# Machine-Cycle Timed Instruction Sequencer

This block is the control unit of a small 8-bit processor core that runs from a fast clock and groups every four clocks into one machine cycle. Each machine cycle is one opcode fetch, one operand read, one memory write, or one internal step with no bus access. Register and memory effects land at the end of the fourth clock. An instruction therefore lasts as long as its chain of machine cycles, so its clock count can be checked at the pins.

After an opcode fetch, a decoder turns the opcode into a short list of pending steps. The list is loaded into a shift queue, and one step is retired per machine cycle until the list is empty. Then the next opcode is fetched. A prefix byte selects a second opcode page, and that costs one more fetch cycle. The supported subset is: no-op, clear accumulator, load of an 8-bit immediate into a register, load of a 16-bit immediate into the address pair, store of the accumulator through that pair, a jump relative to the program counter taken when the zero flag is clear, and a subroutine call. The call stores its return address on a stack that grows downward.

Top module: `mcseq_top`

## Requirements
- R1: A machine cycle is exactly 4 clocks. `mem_rd` and `mem_wr` are never high together, are high only on the 4th clock of a cycle, and `mem_addr` holds steady for the first 3 clocks of the cycle.
- R2: While `rst_n` is low, the unit is in the fetch state with PC = 0x0000, SP = 0xFFFE, the zero flag clear and the prefix flag clear. `op_start` is high and `mem_addr` is 0x0000.
- R3: `op_start` is high on the first clock of each opcode fetch, and only then. The opcode is read from PC, and PC increments. The second byte of a prefixed opcode does not raise `op_start`.
- R4: No-op (0x00), clear accumulator (0xAF), and any opcode outside the subset each take 4 clocks. 0xAF sets A to 0x00 and sets the zero flag.
- R5: Opcode 0xCB, fetched while the prefix flag is clear, sets the flag and costs one more 4-clock fetch. The following byte is decoded from the second page, and every second-page opcode is a no-op, so the pair takes 8 clocks. A 0xCB byte seen in that second fetch is an ordinary second-page opcode and not another prefix.
- R6: 0x21 takes 12 clocks. It reads the low operand byte into L and then the high byte into H, and each read increments PC.
- R7: Opcode 00rrr110, with rrr not equal to 110, takes 8 clocks and loads the next byte into register rrr (B=000, C=001, D=010, E=011, H=100, L=101, A=111). Opcode 0x77 takes 8 clocks and writes A to address {H,L}.
- R8: 0x20 reads a signed offset byte. When the zero flag is set, it takes 8 clocks and execution continues after the offset byte. When the flag is clear, it takes 12 clocks and PC becomes the address after the offset byte plus the sign-extended offset.
- R9: 0xCD takes 24 clocks in this order: opcode fetch, target low byte, target high byte, one idle cycle, a write of PC[15:8] to SP-1, and a write of PC[7:0] to SP-2. PC then holds the target and SP has dropped by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; four periods make one machine cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Byte address of the current machine cycle |
| mem_rd | output | 1 | Read strobe on the last clock of a read cycle |
| mem_wr | output | 1 | Write strobe on the last clock of a write cycle |
| mem_wdata | output | 8 | Byte driven during a write cycle |
| mem_rdata | input | 8 | Read data, sampled when `mem_rd` is high |
| op_start | output | 1 | High on the first clock of every opcode fetch |

## Verification
A single program runs through every instruction kind, and the bench measures the clock distance between successive `op_start` pulses. This separates an instruction that spends too few or too many machine cycles from one that fetches the wrong next address. The relative jump is run once with the zero flag clear (taken, 12 clocks) and once with it set (8 clocks, falls through). This tells a dropped condition apart from a wrong offset. The prefix is run on an ordinary second byte and on a second 0xCB, which shows whether the prefix flag clears on decode. The captured writes check the byte order of the call's return address, the stack pointer start value, and that the accumulator is cleared by 0xAF and then reloaded.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  localparam int AW        = 16;
  localparam int DW        = 8;
  localparam int MAX_STEPS = 5;
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_DST, S_RD_LO, S_RD_HI, S_WR_HL, S_RD_OFS,
    S_ADD_OFS, S_RD_T1, S_RD_T2, S_PUSH_HI, S_PUSH_LO_JMP
  } step_t;

  typedef enum logic {PH_FETCH, PH_EXEC} phase_t;

  localparam logic [7:0] OP_XORA = 8'hAF;
  localparam logic [7:0] OP_LDHL = 8'h21;
  localparam logic [7:0] OP_STHL = 8'h77;
  localparam logic [7:0] OP_JRNZ = 8'h20;
  localparam logic [7:0] OP_CALL = 8'hCD;
  localparam logic [7:0] OP_PFX  = 8'hCB;

  localparam logic [2:0] RI_H = 3'd4;
  localparam logic [2:0] RI_L = 3'd5;
  localparam logic [2:0] RI_A = 3'd7;
endpackage

// File: rtl/mcseq_div.sv
module mcseq_div #(
  parameter int PER = 4,
  localparam int W = $clog2(PER)
) (
  input  logic clk,
  input  logic rst_n,
  output logic first,
  output logic tick
);
  logic [W-1:0] cnt_q, cnt_n;

  assign tick  = (cnt_q == W'(PER - 1));
  assign first = (cnt_q == '0);

  always_comb begin
    cnt_n = tick ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R1: a machine cycle closes and the next opens on the following clock
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> first);
endmodule

// File: rtl/mcseq_stepq.sv
module mcseq_stepq
  import mcseq_pkg::*;
#(
  parameter int DEPTH = MAX_STEPS,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [CW-1:0]           load_n,
  input  step_t [DEPTH-1:0]       load_seq,
  input  logic                    pop,
  output step_t                   head,
  output logic                    last
);
  step_t         q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    step_t nxt;
    if (g == DEPTH - 1) begin : g_tail
      always_comb begin
        nxt = q[g];
        if (load)     nxt = load_seq[g];
        else if (pop) nxt = S_IDLE;
      end
    end else begin : g_body
      always_comb begin
        nxt = q[g];
        if (load)     nxt = load_seq[g];
        else if (pop) nxt = q[g+1];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= S_IDLE;
      else        q[g] <= nxt;
    end
  end

  always_comb begin
    cnt_n = cnt_q;
    if (load)     cnt_n = load_n;
    else if (pop) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign head = q[0];
  assign last = (cnt_q == CW'(1));

  // R9: a new step list never lands on a queue that still holds steps
  p_load_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> cnt_q == '0);
  // R9: the longest list fits in the queue
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> load_n <= CW'(DEPTH));
  // R1: a step is retired only when one is pending
  p_pop_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/mcseq_decode.sv
module mcseq_decode
  import mcseq_pkg::*;
(
  input  logic                    [7:0] opc,
  input  logic                          ext,
  input  logic                          zf,
  output logic                          pfx,
  output logic                          clr_a,
  output logic                    [2:0] dst,
  output logic              [CNT_W-1:0] n,
  output step_t         [MAX_STEPS-1:0] seq
);
  always_comb begin
    pfx   = 1'b0;
    clr_a = 1'b0;
    dst   = opc[5:3];
    n     = '0;
    for (int i = 0; i < MAX_STEPS; i++) seq[i] = S_IDLE;
    if (!ext) begin
      case (opc)
        OP_PFX:  pfx = 1'b1;
        OP_XORA: clr_a = 1'b1;
        OP_LDHL: begin
          n = CNT_W'(2);
          seq[0] = S_RD_LO;
          seq[1] = S_RD_HI;
        end
        OP_STHL: begin
          n = CNT_W'(1);
          seq[0] = S_WR_HL;
        end
        OP_JRNZ: begin
          n = zf ? CNT_W'(1) : CNT_W'(2);
          seq[0] = S_RD_OFS;
          seq[1] = S_ADD_OFS;
        end
        OP_CALL: begin
          n = CNT_W'(5);
          seq[0] = S_RD_T1;
          seq[1] = S_RD_T2;
          seq[2] = S_IDLE;
          seq[3] = S_PUSH_HI;
          seq[4] = S_PUSH_LO_JMP;
        end
        default: begin
          if (opc[7:6] == 2'b00 && opc[2:0] == 3'b110 && opc[5:3] != 3'b110) begin
            n = CNT_W'(1);
            seq[0] = S_RD_DST;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mcseq_top.sv
module mcseq_top
  import mcseq_pkg::*;
#(
  parameter int CLK_PER_MC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          op_start
);
  phase_t        phase_q, phase_n;
  logic [AW-1:0] pc_q, pc_n, sp_q, sp_n;
  logic [DW-1:0] rf_q [8];
  logic [DW-1:0] rf_n [8];
  logic [DW-1:0] t1_q, t1_n, t2_q, t2_n;
  logic          zf_q, zf_n, ext_q, ext_n;
  logic [2:0]    dst_q, dst_n;

  logic                  mc_first, mc_tick;
  logic                  dec_pfx, dec_clr;
  logic [2:0]            dec_dst;
  logic [CNT_W-1:0]      dec_n;
  step_t [MAX_STEPS-1:0] dec_seq;
  step_t                 head;
  logic                  q_last, q_load, q_pop, fetch;

  mcseq_div #(.PER(CLK_PER_MC)) div_i (
    .clk(clk), .rst_n(rst_n), .first(mc_first), .tick(mc_tick)
  );

  mcseq_decode dec_i (
    .opc(mem_rdata), .ext(ext_q), .zf(zf_q), .pfx(dec_pfx), .clr_a(dec_clr),
    .dst(dec_dst), .n(dec_n), .seq(dec_seq)
  );

  mcseq_stepq #(.DEPTH(MAX_STEPS)) q_i (
    .clk(clk), .rst_n(rst_n), .load(q_load), .load_n(dec_n),
    .load_seq(dec_seq), .pop(q_pop), .head(head), .last(q_last)
  );

  assign fetch    = (phase_q == PH_FETCH);
  assign op_start = fetch && mc_first && !ext_q;
  assign q_load   = mc_tick && fetch && !dec_pfx && (dec_n != '0);
  assign q_pop    = mc_tick && !fetch;

  always_comb begin
    mem_addr  = pc_q;
    mem_wdata = rf_q[RI_A];
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    if (fetch) begin
      mem_rd = mc_tick;
    end else begin
      case (head)
        S_WR_HL: begin
          mem_addr = {rf_q[RI_H], rf_q[RI_L]};
          mem_wr   = mc_tick;
        end
        S_PUSH_HI: begin
          mem_addr  = sp_q - AW'(1);
          mem_wdata = pc_q[15:8];
          mem_wr    = mc_tick;
        end
        S_PUSH_LO_JMP: begin
          mem_addr  = sp_q - AW'(1);
          mem_wdata = pc_q[7:0];
          mem_wr    = mc_tick;
        end
        S_RD_DST, S_RD_LO, S_RD_HI, S_RD_OFS, S_RD_T1, S_RD_T2: mem_rd = mc_tick;
        default: ;
      endcase
    end
  end

  always_comb begin
    phase_n = phase_q;
    pc_n    = pc_q;
    sp_n    = sp_q;
    rf_n    = rf_q;
    t1_n    = t1_q;
    t2_n    = t2_q;
    zf_n    = zf_q;
    ext_n   = ext_q;
    dst_n   = dst_q;
    if (mc_tick) begin
      if (fetch) begin
        pc_n = pc_q + AW'(1);
        if (dec_pfx) begin
          ext_n = 1'b1;
        end else begin
          ext_n = 1'b0;
          dst_n = dec_dst;
          if (dec_clr) begin
            rf_n[RI_A] = '0;
            zf_n       = 1'b1;
          end
          if (dec_n != '0) phase_n = PH_EXEC;
        end
      end else begin
        case (head)
          S_RD_DST: begin rf_n[dst_q] = mem_rdata; pc_n = pc_q + AW'(1); end
          S_RD_LO:  begin rf_n[RI_L]  = mem_rdata; pc_n = pc_q + AW'(1); end
          S_RD_HI:  begin rf_n[RI_H]  = mem_rdata; pc_n = pc_q + AW'(1); end
          S_RD_OFS, S_RD_T1: begin t1_n = mem_rdata; pc_n = pc_q + AW'(1); end
          S_RD_T2:  begin t2_n = mem_rdata; pc_n = pc_q + AW'(1); end
          S_ADD_OFS: pc_n = pc_q + {{(AW-DW){t1_q[DW-1]}}, t1_q};
          S_PUSH_HI: sp_n = sp_q - AW'(1);
          S_PUSH_LO_JMP: begin
            sp_n = sp_q - AW'(1);
            pc_n = {t2_q, t1_q};
          end
          default: ;
        endcase
        if (q_last) phase_n = PH_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      sp_q    <= 16'hFFFE;
      for (int i = 0; i < 8; i++) rf_q[i] <= '0;
      t1_q    <= '0;
      t2_q    <= '0;
      zf_q    <= 1'b0;
      ext_q   <= 1'b0;
      dst_q   <= '0;
    end else begin
      phase_q <= phase_n;
      pc_q    <= pc_n;
      sp_q    <= sp_n;
      rf_q    <= rf_n;
      t1_q    <= t1_n;
      t2_q    <= t2_n;
      zf_q    <= zf_n;
      ext_q   <= ext_n;
      dst_q   <= dst_n;
    end
  end

  // R1: strobes are exclusive
  p_rd_wr_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R1: the address holds until a machine cycle closes
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_tick |=> $stable(mem_addr));
  // R3: the fetch marker lasts one clock
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
  // R3: every fetch cycle advances PC by one
  p_fetch_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && mc_tick) |=> pc_q == $past(pc_q) + AW'(1));
  // R4: clearing the accumulator also sets the zero flag
  p_xor_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && mc_tick && !ext_q && mem_rdata == OP_XORA) |=> zf_q && rf_q[RI_A] == '0);
  // R9: each stack write moves SP down by one
  p_push_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !fetch && head != S_WR_HL) |=> sp_q == $past(sp_q) - AW'(1));
endmodule

// File: tb/mcseq_top_tb_top.sv
`timescale 1ns/1ps
module mcseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, op_start;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  prog [256];

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int n = 0;
  int nw = 0;
  int last_start = 0;
  int bad_strobe = 0;
  int          start_cyc  [64];
  logic [15:0] start_addr [64];
  logic [15:0] w_addr [8];
  logic [7:0]  w_data [8];

  always #4 clk = ~clk;

  assign mem_rdata = prog[mem_addr[7:0]];

  mcseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .op_start(op_start)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (op_start && n < 64) begin
        start_addr[n] = mem_addr;
        start_cyc[n]  = cyc;
        last_start    = cyc;
        n++;
      end
      if ((mem_rd || mem_wr) && ((cyc - last_start) % 4 != 3)) bad_strobe++;
      if (mem_wr && nw < 8) begin
        w_addr[nw] = mem_addr;
        w_data[nw] = mem_wdata;
        nw++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {start address, clocks, requirement number}
  localparam logic [31:0] VEC [16] = '{
    {16'h0000, 8'd12, 8'd8},  // R8 taken jump, Z clear after reset
    {16'h0004, 8'd4,  8'd4},  // R4 no-op
    {16'h0005, 8'd4,  8'd4},  // R4 clear accumulator
    {16'h0006, 8'd12, 8'd6},  // R6 16-bit immediate
    {16'h0009, 8'd8,  8'd7},  // R7 store A
    {16'h000A, 8'd8,  8'd7},  // R7 load A
    {16'h000C, 8'd8,  8'd7},  // R7 store A
    {16'h000D, 8'd8,  8'd5},  // R5 prefix + ordinary byte
    {16'h000F, 8'd8,  8'd5},  // R5 prefix + 0xCB
    {16'h0011, 8'd8,  8'd8},  // R8 not taken, Z set
    {16'h0013, 8'd4,  8'd4},  // R4 unsupported opcode
    {16'h0014, 8'd24, 8'd9},  // R9 call
    {16'h0040, 8'd8,  8'd7},  // R7 load H
    {16'h0042, 8'd8,  8'd7},  // R7 load L
    {16'h0044, 8'd8,  8'd7},  // R7 load A
    {16'h0046, 8'd8,  8'd7}   // R7 store A
  };

  initial begin
    for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    prog[8'h00] = 8'h20; prog[8'h01] = 8'h02; prog[8'h02] = 8'hFF; prog[8'h03] = 8'hFF;
    prog[8'h04] = 8'h00; prog[8'h05] = 8'hAF; prog[8'h06] = 8'h21; prog[8'h07] = 8'h34;
    prog[8'h08] = 8'h12; prog[8'h09] = 8'h77; prog[8'h0A] = 8'h3E; prog[8'h0B] = 8'h5A;
    prog[8'h0C] = 8'h77; prog[8'h0D] = 8'hCB; prog[8'h0E] = 8'h37; prog[8'h0F] = 8'hCB;
    prog[8'h10] = 8'hCB; prog[8'h11] = 8'h20; prog[8'h12] = 8'h05; prog[8'h13] = 8'hD3;
    prog[8'h14] = 8'hCD; prog[8'h15] = 8'h40; prog[8'h16] = 8'h00;
    prog[8'h40] = 8'h26; prog[8'h41] = 8'hAB; prog[8'h42] = 8'h2E; prog[8'h43] = 8'hCD;
    prog[8'h44] = 8'h3E; prog[8'h45] = 8'h99; prog[8'h46] = 8'h77;

    // R2: state held in reset
    repeat (3) @(negedge clk);
    chk(op_start == 1'b1, "R2 op_start in reset", 32'(op_start), 32'd1);
    chk(mem_addr == 16'h0000, "R2 address in reset", 32'(mem_addr), 32'h0);
    chk(!mem_rd && !mem_wr, "R2 strobes in reset", {mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;

    while (n < 17 && cyc < 3000) @(posedge clk);
    chk(n >= 17, "watchdog main run", 32'(n), 32'd17);

    for (int i = 0; i < 16; i++) begin
      // R3: each instruction starts at the expected fetch address
      chk(start_addr[i] == VEC[i][31:16], $sformatf("R%0d start addr #%0d", VEC[i][7:0], i),
          32'(start_addr[i]), 32'(VEC[i][31:16]));
      chk(start_cyc[i+1] - start_cyc[i] == int'(VEC[i][15:8]),
          $sformatf("R%0d clocks #%0d", VEC[i][7:0], i),
          32'(start_cyc[i+1] - start_cyc[i]), 32'(VEC[i][15:8]));
    end
    chk(start_addr[16] == 16'h0047, "R9 R7 final fetch", 32'(start_addr[16]), 32'h47);

    chk(nw == 5, "R7 R9 write count", 32'(nw), 32'd5);
    chk(w_addr[0] == 16'h1234 && w_data[0] == 8'h00, "R4 A cleared store",
        {w_addr[0], w_data[0]}, 32'h123400);
    chk(w_addr[1] == 16'h1234 && w_data[1] == 8'h5A, "R7 store A via HL",
        {w_addr[1], w_data[1]}, 32'h12345A);
    chk(w_addr[2] == 16'hFFFD && w_data[2] == 8'h00, "R9 push high",
        {w_addr[2], w_data[2]}, 32'hFFFD00);
    chk(w_addr[3] == 16'hFFFC && w_data[3] == 8'h17, "R9 push low",
        {w_addr[3], w_data[3]}, 32'hFFFC17);
    chk(w_addr[4] == 16'hABCD && w_data[4] == 8'h99, "R7 store via loaded HL",
        {w_addr[4], w_data[4]}, 32'hABCD99);
    chk(bad_strobe == 0, "R1 strobe on 4th clock", 32'(bad_strobe), 32'd0);

    // R2: reset mid-run returns to address 0 with Z clear (jump taken again)
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(mem_addr == 16'h0000 && op_start, "R2 async reset", {mem_addr, 15'd0, op_start}, 32'h1);
    @(negedge clk);
    begin
      int base;
      base = n;
      rst_n = 1'b1;
      while (n < base + 2 && cyc < 6000) @(posedge clk);
      chk(n >= base + 2, "watchdog after reset", 32'(n), 32'(base + 2));
      chk(start_addr[base] == 16'h0000 && start_addr[base+1] == 16'h0004,
          "R2 R8 restart jump", {start_addr[base], start_addr[base+1]}, 32'h00000004);
      chk(start_cyc[base+1] - start_cyc[base] == 12, "R8 taken after reset",
          32'(start_cyc[base+1] - start_cyc[base]), 32'd12);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule